// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Coherence Controller

This block sits between one processor and a shared snooping bus. It keeps a small direct-mapped, write-back cache. Every line is in one of three coherence states: Invalid (holds nothing), Shared (clean and readable, other caches may hold it too) or Exclusive (the only copy, writable and dirty). Read hits and write hits to Exclusive lines finish locally. Every other access goes to the bus: the controller raises a request, waits for a single-cycle grant, and only then changes the line.

On the bus side the controller watches transactions from the other caches. A foreign read miss that finds a dirty local copy makes this cache drive its data and drop the line to Shared. A foreign write miss removes any local copy, and the data is supplied first if the line was dirty. When a write hits a Shared line, the controller issues a write miss so that the other copies are invalidated. When a dirty line has to be replaced by a block with a different tag, its old contents are written back first.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid: the first read of any address raises `bus_req` with command read-miss (01), and `cpu_ready`, `bus_req` and `snp_hit` are low while no request is present.
- R2: A read miss issues command 01 with `bus_addr` equal to the processor address. On the grant cycle the line fills as Shared from `bus_rdata`, and `cpu_ready` rises in the next cycle with that data on `cpu_rdata`.
- R3: A read to a Shared or Exclusive line with a matching tag raises `cpu_ready` in the same cycle with the stored data, and no bus request is made.
- R4: While a bus request waits for `bus_gnt`, `bus_req` stays high, `cpu_ready` stays low and the line is not altered. The line changes only in a cycle with a grant or a local hit.
- R5: A write to a Shared line issues command write-miss (10). After the grant the line is Exclusive, so later writes and reads to it finish without bus traffic and return the last value written.
- R6: A write to an Invalid line, or to a Shared line with another tag, issues a single write-miss (10) with no write-back and installs the line Exclusive holding the written data.
- R7: When a line held Exclusive must be replaced by another tag, the controller first issues command write-back (11), with `bus_addr` set to the old block's address and `bus_wdata` set to its data. It issues the miss for the new address only after that grant.
- R8: A snooped read miss (01) that matches an Exclusive line raises `snp_hit` and `snp_supply` and drives the dirty data on `snp_data` in the same cycle. The line becomes Shared, so the next local write issues a write-miss.
- R9: A snooped write miss (10) that matches a line makes it Invalid. If the line was Exclusive, its data is supplied on `snp_data` with `snp_supply` high, and if it was Shared, `snp_supply` stays low. The next local read issues a read-miss.
- R10: In a cycle with `snp_valid` high the processor lookup yields: `cpu_ready` is low even for a hit, and the hit completes in the next cycle without the snoop.
- R11: A snoop whose tag differs from the stored one, or whose command is write-back (11), has no effect: `snp_hit` and `snp_supply` stay low and the line still hits afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W (8) | Word address; low INDEX_W bits select the line |
| cpu_wdata | input | DATA_W (16) | Write data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | DATA_W (16) | Read data, valid with `cpu_ready` |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant; the transaction completes in this cycle |
| bus_cmd | output | 2 | 00 none, 01 read-miss, 10 write-miss, 11 write-back |
| bus_addr | output | ADDR_W (8) | Transaction address |
| bus_wdata | output | DATA_W (16) | Write-back data |
| bus_rdata | input | DATA_W (16) | Fill data, sampled on grant of a miss |
| snp_valid | input | 1 | Foreign transaction present on the bus |
| snp_cmd | input | 2 | Foreign command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W (8) | Foreign transaction address |
| snp_hit | output | 1 | This cache holds the snooped block |
| snp_supply | output | 1 | This cache drives the dirty block on `snp_data` |
| snp_data | output | DATA_W (16) | Supplied data, zero when not supplying |

## Verification
Processor accesses are applied to each line state in turn: reads and writes to Invalid, Shared and Exclusive lines, with matching and with conflicting tags. Counting and decoding the bus transactions then separates a local hit, a plain miss, a write upgrading a Shared line, and a dirty eviction that has to put a write-back ahead of its miss. The grant is held back for several cycles to show that nothing completes early. Foreign read and write misses are snooped against dirty, clean and absent lines, and against write-back commands. A later local access then shows whether the line was downgraded, invalidated or left alone. One test places a snoop and a processor hit in the same cycle to show which one wins.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'b00,
    LN_SHR = 2'b01,
    LN_EXC = 2'b10
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE   = 2'b00,
    BC_RDMISS = 2'b01,
    BC_WRMISS = 2'b10,
    BC_WBACK  = 2'b11
  } bus_cmd_e;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_e          a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_e          b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  line_st_e          wr_st,
  input  logic              wr_fill,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int LINES = 1 << IDX_W;

  line_st_e          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st_q[i] <= LN_INV;
      else if (sel) st_q[i] <= wr_st;
    end

    always_ff @(posedge clk) begin
      if (sel && wr_fill) begin
        tag_q[i]  <= wr_tag;
        data_q[i] <= wr_data;
      end
    end
  end

  assign a_st   = st_q[a_idx];
  assign a_tag  = tag_q[a_idx];
  assign a_data = data_q[a_idx];
  assign b_st   = st_q[b_idx];
  assign b_tag  = tag_q[b_idx];
  assign b_data = data_q[b_idx];
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  bus_cmd_e          snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  line_st_e          ln_st,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic [DATA_W-1:0] ln_data,
  output logic              snp_hit,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data,
  output logic              upd_en,
  output line_st_e          upd_st
);
  logic miss_cmd;
  logic match;

  always_comb begin
    miss_cmd   = (snp_cmd == BC_RDMISS) || (snp_cmd == BC_WRMISS);
    match      = snp_valid && miss_cmd && (ln_st != LN_INV) && (ln_tag == snp_tag);
    snp_hit    = match;
    snp_supply = match && (ln_st == LN_EXC);
    snp_data   = snp_supply ? ln_data : '0;
    upd_en     = match;
    upd_st     = ln_st;
    if (match) begin
      if (snp_cmd == BC_WRMISS) upd_st = LN_INV;
      else if (ln_st == LN_EXC) upd_st = LN_SHR;
    end
  end

  AST_WBACK_SNOOP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd == BC_WBACK) |-> (!snp_hit && !snp_supply)) else $error("AST_WBACK_SNOOP_INERT"); // R11
endmodule

// File: rtl/msi_proc_fsm.sv
module msi_proc_fsm
  import msi_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [TAG_W-1:0]  cpu_tag,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  line_st_e          ln_st,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic              snp_valid,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              cpu_ready,
  output logic              bus_req,
  output bus_cmd_e          bus_cmd,
  output logic              wr_en,
  output line_st_e          wr_st,
  output logic              wr_fill,
  output logic [DATA_W-1:0] wr_data
);
  typedef enum logic {PS_IDLE, PS_BUSY} pstate_e;

  pstate_e st_q, st_d;
  logic    tag_hit, hit, need_wb;
  bus_cmd_e want_cmd;

  always_comb begin
    tag_hit  = (ln_st != LN_INV) && (ln_tag == cpu_tag);
    hit      = cpu_we ? (tag_hit && ln_st == LN_EXC) : tag_hit;
    need_wb  = (ln_st == LN_EXC) && (ln_tag != cpu_tag);
    want_cmd = need_wb ? BC_WBACK : (cpu_we ? BC_WRMISS : BC_RDMISS);

    cpu_ready = (st_q == PS_IDLE) && cpu_req && !snp_valid && hit;
    bus_req   = (st_q == PS_BUSY);
    bus_cmd   = bus_req ? want_cmd : BC_NONE;

    st_d = st_q;
    case (st_q)
      PS_IDLE: if (cpu_req && !snp_valid && !hit) st_d = PS_BUSY;
      PS_BUSY: if (bus_gnt && !need_wb)           st_d = PS_IDLE;
      default: st_d = PS_IDLE;
    endcase

    wr_en   = 1'b0;
    wr_st   = ln_st;
    wr_fill = 1'b0;
    wr_data = cpu_wdata;
    if (cpu_ready && cpu_we) begin
      wr_en   = 1'b1;
      wr_st   = LN_EXC;
      wr_fill = 1'b1;
    end else if (bus_req && bus_gnt) begin
      wr_en = 1'b1;
      if (need_wb) begin
        wr_st = LN_INV;
      end else begin
        wr_fill = 1'b1;
        wr_st   = cpu_we ? LN_EXC : LN_SHR;
        wr_data = cpu_we ? cpu_wdata : bus_rdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PS_IDLE;
    else        st_q <= st_d;
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req) else $error("AST_REQ_HELD"); // R4
  AST_WB_EVICTS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt && bus_cmd == BC_WBACK) |=> (bus_cmd != BC_WBACK)) else $error("AST_WB_EVICTS"); // R7
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int INDEX_W = 2,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_hit,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W = ADDR_W - INDEX_W;

  logic rst_meta, rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_i  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_i  <= rst_meta;
    end
  end

  logic [INDEX_W-1:0] c_idx, s_idx;
  logic [TAG_W-1:0]   c_tag, s_tag;
  assign c_idx = cpu_addr[INDEX_W-1:0];
  assign c_tag = cpu_addr[ADDR_W-1:INDEX_W];
  assign s_idx = snp_addr[INDEX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:INDEX_W];

  line_st_e          a_st, b_st;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [DATA_W-1:0] a_data, b_data;

  logic              f_wr_en, f_wr_fill;
  line_st_e          f_wr_st;
  logic [DATA_W-1:0] f_wr_data;
  bus_cmd_e          f_cmd;
  logic              s_upd_en;
  line_st_e          s_upd_st;

  logic              wr_en, wr_fill;
  logic [INDEX_W-1:0] wr_idx;
  line_st_e          wr_st;

  always_comb begin
    if (s_upd_en) begin
      wr_en   = 1'b1;
      wr_idx  = s_idx;
      wr_st   = s_upd_st;
      wr_fill = 1'b0;
    end else begin
      wr_en   = f_wr_en;
      wr_idx  = c_idx;
      wr_st   = f_wr_st;
      wr_fill = f_wr_fill;
    end
  end

  msi_line_store #(.IDX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n_i),
    .a_idx(c_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
    .b_idx(s_idx), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_st(wr_st), .wr_fill(wr_fill),
    .wr_tag(c_tag), .wr_data(f_wr_data)
  );

  msi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rst_n(rst_n_i),
    .snp_valid(snp_valid), .snp_cmd(bus_cmd_e'(snp_cmd)), .snp_tag(s_tag),
    .ln_st(b_st), .ln_tag(b_tag), .ln_data(b_data),
    .snp_hit(snp_hit), .snp_supply(snp_supply), .snp_data(snp_data),
    .upd_en(s_upd_en), .upd_st(s_upd_st)
  );

  msi_proc_fsm #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n_i),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_tag(c_tag), .cpu_wdata(cpu_wdata),
    .ln_st(a_st), .ln_tag(a_tag),
    .snp_valid(snp_valid), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
    .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_cmd(f_cmd),
    .wr_en(f_wr_en), .wr_st(f_wr_st), .wr_fill(f_wr_fill), .wr_data(f_wr_data)
  );

  assign cpu_rdata = a_data;
  assign bus_cmd   = f_cmd;
  assign bus_addr  = !bus_req ? '0 : (f_cmd == BC_WBACK) ? {a_tag, c_idx} : cpu_addr;
  assign bus_wdata = (f_cmd == BC_WBACK) ? a_data : '0;

  AST_RDY_YIELDS_SNOOP: assert property (@(posedge clk) disable iff (!rst_n_i)
    snp_valid |-> !cpu_ready) else $error("AST_RDY_YIELDS_SNOOP"); // R10
  AST_RDY_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n_i)
    cpu_ready |-> cpu_req) else $error("AST_RDY_HAS_REQ"); // R3
  AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n_i)
    bus_gnt |-> bus_req) else $error("AST_GNT_HAS_REQ"); // R4
  AST_PROC_UPD_GATED: assert property (@(posedge clk) disable iff (!rst_n_i)
    (f_wr_en && !cpu_ready) |-> bus_gnt) else $error("AST_PROC_UPD_GATED"); // R4
  AST_SUPPLY_DOWNGRADES: assert property (@(posedge clk) disable iff (!rst_n_i)
    snp_supply |-> (wr_en && wr_st != LN_EXC)) else $error("AST_SUPPLY_DOWNGRADES"); // R8
endmodule

// File: tb/msi_snoop_ctrl_test.sv
`timescale 1ns/1ps
module msi_snoop_ctrl_test;
  logic clk = 1'b0;
  logic rst_n;
  logic cpu_req, cpu_we, cpu_ready;
  logic [7:0] cpu_addr;
  logic [15:0] cpu_wdata, cpu_rdata;
  logic bus_req, bus_gnt;
  logic [1:0] bus_cmd;
  logic [7:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic snp_valid;
  logic [1:0] snp_cmd;
  logic [7:0] snp_addr;
  logic snp_hit, snp_supply;
  logic [15:0] snp_data;

  always #2.5 clk = ~clk;

  msi_snoop_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_hit(snp_hit), .snp_supply(snp_supply), .snp_data(snp_data)
  );

  int n_run = 0, n_fail = 0;
  logic [15:0] mem [256];
  logic [1:0]  tx_cmd  [4];
  logic [7:0]  tx_addr [4];
  logic [15:0] tx_data [4];
  int          tx_n;
  logic [15:0] op_rd;
  bit          wait_ok;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_op(input bit we, input logic [7:0] addr, input logic [15:0] wd,
                        input int gnt_wait);
    int hold = gnt_wait;
    bit done = 0;
    tx_n = 0;
    wait_ok = 1;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    for (int cyc = 0; cyc < 40 && !done; cyc++) begin
      #1;
      if (cpu_ready) begin
        op_rd = cpu_rdata;
        done = 1;
      end else if (bus_req) begin
        if (hold > 0) begin
          hold--;
        end else if (tx_n < 4) begin
          tx_cmd[tx_n] = bus_cmd; tx_addr[tx_n] = bus_addr; tx_data[tx_n] = bus_wdata;
          tx_n++;
          bus_gnt = 1;
          bus_rdata = mem[bus_addr];
          if (bus_cmd == 2'b11) mem[bus_addr] = bus_wdata;
        end
      end else if (gnt_wait > 0 && tx_n == 0 && hold < gnt_wait) begin
        wait_ok = 0;
      end
      @(negedge clk);
      bus_gnt = 0;
    end
    cpu_req = 0;
    if (!done) chk("no completion", 0, 1);
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [7:0] addr,
                       input bit exp_hit, input bit exp_sup, input logic [15:0] exp_data,
                       input string req);
    @(negedge clk);
    snp_valid = 1; snp_cmd = cmd; snp_addr = addr;
    #1;
    chk({req, " snp_hit"}, {31'b0, snp_hit}, {31'b0, exp_hit});
    chk({req, " snp_supply"}, {31'b0, snp_supply}, {31'b0, exp_sup});
    if (exp_sup) begin
      chk({req, " snp_data"}, {16'b0, snp_data}, {16'b0, exp_data});
      if (cmd == 2'b10 || cmd == 2'b01) mem[addr] = snp_data;
    end
    @(negedge clk);
    snp_valid = 0;
  endtask

  task automatic t_reset_and_fill;
    chk("R1 ready idle", {31'b0, cpu_ready}, 0);
    chk("R1 bus_req idle", {31'b0, bus_req}, 0);
    chk("R1 snp_hit idle", {31'b0, snp_hit}, 0);
    cpu_op(0, 8'h10, 0, 0);
    chk("R1 R2 tx count", tx_n, 1);
    chk("R2 read-miss cmd", {30'b0, tx_cmd[0]}, 1);
    chk("R2 miss addr", {24'b0, tx_addr[0]}, 32'h10);
    chk("R2 fill data", {16'b0, op_rd}, 32'h1010);
  endtask

  task automatic t_read_hit;
    cpu_op(0, 8'h10, 0, 0);
    chk("R3 no bus on hit", tx_n, 0);
    chk("R3 hit data", {16'b0, op_rd}, 32'h1010);
  endtask

  task automatic t_upgrade;
    cpu_op(1, 8'h10, 16'hBBBB, 0);
    chk("R5 write to shared tx", tx_n, 1);
    chk("R5 write-miss cmd", {30'b0, tx_cmd[0]}, 2);
    cpu_op(1, 8'h10, 16'hCCCC, 0);
    chk("R5 exclusive write hit", tx_n, 0);
    cpu_op(0, 8'h10, 0, 0);
    chk("R5 read after writes tx", tx_n, 0);
    chk("R5 read last write", {16'b0, op_rd}, 32'hCCCC);
  endtask

  task automatic t_delayed_grant;
    cpu_op(0, 8'h21, 0, 4);
    chk("R4 request held without grant", {31'b0, wait_ok}, 1);
    chk("R4 single tx after wait", tx_n, 1);
    chk("R4 data after wait", {16'b0, op_rd}, 32'h1021);
  endtask

  task automatic t_evict;
    cpu_op(1, 8'h20, 16'hDDDD, 0);
    chk("R7 two tx", tx_n, 2);
    chk("R7 writeback first", {30'b0, tx_cmd[0]}, 3);
    chk("R7 victim addr", {24'b0, tx_addr[0]}, 32'h10);
    chk("R7 victim data", {16'b0, tx_data[0]}, 32'hCCCC);
    chk("R7 then write-miss", {30'b0, tx_cmd[1]}, 2);
    chk("R7 new addr", {24'b0, tx_addr[1]}, 32'h20);
    cpu_op(0, 8'h20, 0, 0);
    chk("R7 new line hit", tx_n, 0);
    chk("R7 new line data", {16'b0, op_rd}, 32'hDDDD);
  endtask

  task automatic t_snoop_read;
    snoop(2'b01, 8'h20, 1, 1, 16'hDDDD, "R8");
    cpu_op(1, 8'h20, 16'hEEEE, 0);
    chk("R8 downgraded write tx", tx_n, 1);
    chk("R8 downgraded write cmd", {30'b0, tx_cmd[0]}, 2);
  endtask

  task automatic t_snoop_write;
    snoop(2'b10, 8'h20, 1, 1, 16'hEEEE, "R9 dirty");
    cpu_op(0, 8'h20, 0, 0);
    chk("R9 invalidated read tx", tx_n, 1);
    chk("R9 invalidated read cmd", {30'b0, tx_cmd[0]}, 1);
    chk("R9 refetch data", {16'b0, op_rd}, 32'hEEEE);
    snoop(2'b10, 8'h20, 1, 0, 16'h0, "R9 clean");
    cpu_op(0, 8'h20, 0, 0);
    chk("R9 clean invalidated tx", tx_n, 1);
  endtask

  task automatic t_no_effect;
    snoop(2'b01, 8'h30, 0, 0, 16'h0, "R11 other tag");
    snoop(2'b11, 8'h20, 0, 0, 16'h0, "R11 writeback cmd");
    cpu_op(0, 8'h20, 0, 0);
    chk("R11 line still hits", tx_n, 0);
  endtask

  task automatic t_priority;
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 8'h20;
    snp_valid = 1; snp_cmd = 2'b01; snp_addr = 8'h05;
    #1;
    chk("R10 ready held by snoop", {31'b0, cpu_ready}, 0);
    @(negedge clk);
    snp_valid = 0;
    #1;
    chk("R10 hit after snoop", {31'b0, cpu_ready}, 1);
    chk("R10 data", {16'b0, cpu_rdata}, 32'hEEEE);
    @(negedge clk);
    cpu_req = 0;
  endtask

  task automatic t_write_invalid;
    cpu_op(1, 8'h02, 16'h1234, 0);
    chk("R6 single tx", tx_n, 1);
    chk("R6 write-miss cmd", {30'b0, tx_cmd[0]}, 2);
    chk("R6 addr", {24'b0, tx_addr[0]}, 32'h02);
    cpu_op(0, 8'h02, 0, 0);
    chk("R6 installed data", {16'b0, op_rd}, 32'h1234);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h1000 + 16'(i);
    rst_n = 0; cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
    bus_gnt = 0; bus_rdata = 0; snp_valid = 0; snp_cmd = 0; snp_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset_and_fill();
    t_read_hit();
    t_upgrade();
    t_delayed_grant();
    t_evict();
    t_snoop_read();
    t_snoop_write();
    t_no_effect();
    t_priority();
    t_write_invalid();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule